// File: doc/BRIEF.md
# Signed Matrix Multiplier with Pre-Transposed Right Operand

This block computes the product C = A × B of two signed integer matrices. A has R rows and K columns. B has K rows and N columns, but it is delivered already transposed, as an N×K matrix BT. As a result, both stored operands have rows of length K, and every result element C[i][j] is the dot product of row i of A and row j of BT.

Operation alternates between two phases. In the load phase a single data port accepts one element per valid beat. The first R·K beats fill A in row-major order, and the following N·K beats fill BT in row-major order. For example, B = [[1,1,2],[0,4,0]] is sent as 1, 0, 1, 4, 2, 0. Beats without valid are skipped and do not advance the load position. When the last BT element has been written, the compute phase starts on its own. A sequencer walks i (outer), j (middle) and k (inner) and feeds one element pair per cycle to a self-timed dot-product accumulator of fixed length K. Each finished element leaves the block with its row and column index and a one-cycle valid. A one-cycle done pulse follows the final element, and the block then returns to the load phase.

Top module: `mm_matmul`

## Requirements
- R1: While reset is asserted, and in the cycles after reset is released before any data is loaded, `res_valid` and `job_done` are low.
- R2: In the load phase, the first ROWS_A·DEPTH beats with `in_valid` high write A in row-major order (column index fastest). The next COLS_B·DEPTH beats write BT in row-major order. A beat writes at most one of the two matrices.
- R3: Each result equals the sum over k of A[i][k]·BT[j][k]. Elements are signed two's complement of DW bits. The result is signed with 2·DW + ceil(log2(DEPTH)) bits, so it cannot overflow, even when every element is −2^(DW−1).
- R4: Results leave in the order i outer, j inner. `res_row` carries i and `res_col` carries j. The n-th result of a job (counting from 0) has i = n / COLS_B and j = n mod COLS_B.
- R5: The first result of a job is valid DEPTH+1 clock edges after the edge that takes the final BT element. Each further result follows the previous one by exactly DEPTH cycles, so a job emits ROWS_A·COLS_B results in total.
- R6: `job_done` is high for exactly one cycle, the cycle after the final result's valid. It is never high together with `res_valid`. The block is ready to load the next job afterwards.
- R7: `in_valid` beats during the compute phase have no effect: they do not change the stored operands, the results, or the load position of the next job.
- R8: A cycle with `in_valid` low writes nothing and does not advance the load position, so gaps between load beats are allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Load beat qualifier |
| in_data | input | DW | Signed operand element for the current load beat |
| res_valid | output | 1 | One-cycle valid for a result element |
| res_row | output | clog2(ROWS_A) (min 1) | Row index i of the result |
| res_col | output | clog2(COLS_B) (min 1) | Column index j of the result |
| res_data | output | 2·DW+clog2(DEPTH) | Signed result element C[i][j] |
| job_done | output | 1 | One-cycle pulse after the last result of a job |

## Verification
The hardest condition to reach from the ports is a set of load beats that arrive while the block is busy computing. Those beats must leave no trace. Their absence shows up only indirectly, through the correctness of the current results and through the alignment of the following job's load. The stimulus therefore keeps `in_valid` high with random data for most of selected compute phases. It then loads a fresh job and compares every element of it, together with its timing, against a product computed in the bench. The same sweep covers gapped loads, all-minimum operands for the widest sum, and a long run of random signed matrices.

// File: rtl/mm_pkg.sv
package mm_pkg;

  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  // index width for a dimension of n entries, never narrower than one bit
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // width of a signed sum of k products of two dw-bit signed values
  function automatic int sum_bits(input int dw, input int k);
    return 2 * dw + ((k > 1) ? $clog2(k) : 0);
  endfunction

endpackage

// File: rtl/mm_regbank.sv
module mm_regbank
  import mm_pkg::*;
#(
  parameter int ROWS = 3,
  parameter int COLS = 2,
  parameter int DW   = 8,
  localparam int RW  = idx_bits(ROWS),
  localparam int CW  = idx_bits(COLS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [RW-1:0]        wr_row,
  input  logic [CW-1:0]        wr_col,
  input  logic [DW-1:0]        wr_data,
  input  logic [RW-1:0]        rd_row,
  input  logic [CW-1:0]        rd_col,
  output logic signed [DW-1:0] rd_data
);

  localparam int CELLS = ROWS * COLS;

  logic [CELLS*DW-1:0] flat;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      logic [DW-1:0] q;
      logic          hit;
      assign hit = we && (wr_row == RW'(r)) && (wr_col == CW'(c));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wr_data;
      end
      assign flat[(r*COLS+c)*DW +: DW] = q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        if (rd_row == RW'(r) && rd_col == CW'(c))
          rd_data = flat[(r*COLS+c)*DW +: DW];
      end
    end
  end

endmodule

// File: rtl/mm_dotacc.sv
module mm_dotacc
  import mm_pkg::*;
#(
  parameter int DEPTH = 2,
  parameter int DW    = 8,
  parameter int TW    = 4,
  localparam int SW   = sum_bits(DW, DEPTH),
  localparam int KW   = idx_bits(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 beat_en,
  input  logic signed [DW-1:0] lhs,
  input  logic signed [DW-1:0] rhs,
  input  logic [TW-1:0]        tag_in,
  output logic                 beat_last,
  output logic                 res_valid,
  output logic signed [SW-1:0] res_sum,
  output logic [TW-1:0]        res_tag
);

  localparam logic [KW-1:0] K_LAST = KW'(DEPTH - 1);

  function automatic logic signed [SW-1:0] mac(input logic signed [SW-1:0] acc_in,
                                               input logic signed [DW-1:0] a,
                                               input logic signed [DW-1:0] b);
    logic signed [2*DW-1:0] prod;
    prod = a * b;
    return acc_in + SW'(prod);
  endfunction

  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] acc_next;
  logic [KW-1:0]        kcnt;

  assign acc_next  = mac(acc, lhs, rhs);
  assign beat_last = beat_en && (kcnt == K_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      kcnt      <= '0;
      res_valid <= 1'b0;
      res_sum   <= '0;
      res_tag   <= '0;
    end else begin
      res_valid <= 1'b0;
      if (beat_en) begin
        if (beat_last) begin
          res_valid <= 1'b1;
          res_sum   <= acc_next;
          res_tag   <= tag_in;
          acc       <= '0;
          kcnt      <= '0;
        end else begin
          acc  <= acc_next;
          kcnt <= kcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mm_seq.sv
module mm_seq
  import mm_pkg::*;
#(
  parameter int ROWS_A = 3,
  parameter int DEPTH  = 2,
  parameter int COLS_B = 3,
  localparam int IW    = idx_bits(ROWS_A),
  localparam int JW    = idx_bits(COLS_B),
  localparam int KW    = idx_bits(DEPTH),
  localparam int LRW   = idx_bits((ROWS_A > COLS_B) ? ROWS_A : COLS_B)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           wr_a,
  output logic           wr_b,
  output logic [LRW-1:0] wr_row,
  output logic [KW-1:0]  wr_col,
  output logic [IW-1:0]  rd_i,
  output logic [JW-1:0]  rd_j,
  output logic [KW-1:0]  rd_k,
  output logic           beat_en,
  output logic           running
);

  localparam logic [KW-1:0]  K_LAST  = KW'(DEPTH - 1);
  localparam logic [IW-1:0]  I_LAST  = IW'(ROWS_A - 1);
  localparam logic [JW-1:0]  J_LAST  = JW'(COLS_B - 1);
  localparam logic [LRW-1:0] LA_LAST = LRW'(ROWS_A - 1);
  localparam logic [LRW-1:0] LB_LAST = LRW'(COLS_B - 1);

  phase_e         phase;
  logic [LRW-1:0] ld_row;
  logic [KW-1:0]  ld_col;
  logic           ld_sel;
  logic [IW-1:0]  ci;
  logic [JW-1:0]  cj;
  logic [KW-1:0]  ck;

  logic load_beat, row_end, mat_end, k_end, j_end, run_end;

  assign load_beat = (phase == PH_LOAD) && in_valid;
  assign row_end   = (ld_col == K_LAST);
  assign mat_end   = row_end && (ld_row == (ld_sel ? LB_LAST : LA_LAST));
  assign k_end     = (ck == K_LAST);
  assign j_end     = k_end && (cj == J_LAST);
  assign run_end   = (phase == PH_RUN) && j_end && (ci == I_LAST);

  assign wr_a    = load_beat && !ld_sel;
  assign wr_b    = load_beat && ld_sel;
  assign wr_row  = ld_row;
  assign wr_col  = ld_col;
  assign rd_i    = ci;
  assign rd_j    = cj;
  assign rd_k    = ck;
  assign beat_en = (phase == PH_RUN);
  assign running = (phase == PH_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_LOAD;
      ld_row <= '0;
      ld_col <= '0;
      ld_sel <= 1'b0;
      ci     <= '0;
      cj     <= '0;
      ck     <= '0;
    end else if (phase == PH_LOAD) begin
      if (load_beat) begin
        if (row_end) begin
          ld_col <= '0;
          if (mat_end) begin
            ld_row <= '0;
            if (ld_sel) begin
              ld_sel <= 1'b0;
              phase  <= PH_RUN;
            end else begin
              ld_sel <= 1'b1;
            end
          end else begin
            ld_row <= ld_row + 1'b1;
          end
        end else begin
          ld_col <= ld_col + 1'b1;
        end
      end
    end else begin
      if (run_end) begin
        ci    <= '0;
        cj    <= '0;
        ck    <= '0;
        phase <= PH_LOAD;
      end else if (j_end) begin
        ck <= '0;
        cj <= '0;
        ci <= ci + 1'b1;
      end else if (k_end) begin
        ck <= '0;
        cj <= cj + 1'b1;
      end else begin
        ck <= ck + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mm_matmul.sv
module mm_matmul
  import mm_pkg::*;
#(
  parameter int ROWS_A = 3,
  parameter int DEPTH  = 2,
  parameter int COLS_B = 3,
  parameter int DW     = 8,
  localparam int IW    = idx_bits(ROWS_A),
  localparam int JW    = idx_bits(COLS_B),
  localparam int SW    = sum_bits(DW, DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_data,
  output logic                 res_valid,
  output logic [IW-1:0]        res_row,
  output logic [JW-1:0]        res_col,
  output logic signed [SW-1:0] res_data,
  output logic                 job_done
);

  localparam int KW  = idx_bits(DEPTH);
  localparam int LRW = idx_bits((ROWS_A > COLS_B) ? ROWS_A : COLS_B);
  localparam int TW  = IW + JW;
  localparam logic [IW-1:0] I_LAST = IW'(ROWS_A - 1);
  localparam logic [JW-1:0] J_LAST = JW'(COLS_B - 1);

  // named internal events, observed by the bound checker
  logic           wr_a_en, wr_bt_en, run_phase, beat_en, beat_last;
  logic [LRW-1:0] wr_row;
  logic [KW-1:0]  wr_col;
  logic [IW-1:0]  rd_i;
  logic [JW-1:0]  rd_j;
  logic [KW-1:0]  rd_k;
  logic signed [DW-1:0] a_elem, bt_elem;
  logic [TW-1:0]  tag_out;
  logic           final_fire;

  mm_seq #(.ROWS_A(ROWS_A), .DEPTH(DEPTH), .COLS_B(COLS_B)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .wr_a    (wr_a_en),
    .wr_b    (wr_bt_en),
    .wr_row  (wr_row),
    .wr_col  (wr_col),
    .rd_i    (rd_i),
    .rd_j    (rd_j),
    .rd_k    (rd_k),
    .beat_en (beat_en),
    .running (run_phase)
  );

  mm_regbank #(.ROWS(ROWS_A), .COLS(DEPTH), .DW(DW)) u_bank_a (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_a_en),
    .wr_row (IW'(wr_row)),
    .wr_col (wr_col),
    .wr_data(in_data),
    .rd_row (rd_i),
    .rd_col (rd_k),
    .rd_data(a_elem)
  );

  mm_regbank #(.ROWS(COLS_B), .COLS(DEPTH), .DW(DW)) u_bank_bt (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (wr_bt_en),
    .wr_row (JW'(wr_row)),
    .wr_col (wr_col),
    .wr_data(in_data),
    .rd_row (rd_j),
    .rd_col (rd_k),
    .rd_data(bt_elem)
  );

  mm_dotacc #(.DEPTH(DEPTH), .DW(DW), .TW(TW)) u_dot (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_en  (beat_en),
    .lhs      (a_elem),
    .rhs      (bt_elem),
    .tag_in   ({rd_i, rd_j}),
    .beat_last(beat_last),
    .res_valid(res_valid),
    .res_sum  (res_data),
    .res_tag  (tag_out)
  );

  assign res_row    = tag_out[TW-1:JW];
  assign res_col    = tag_out[JW-1:0];
  assign final_fire = res_valid && (res_row == I_LAST) && (res_col == J_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) job_done <= 1'b0;
    else        job_done <= final_fire;
  end

endmodule

// File: rtl/mm_matmul_chk.sv
module mm_matmul_chk #(
  parameter int ROWS_A = 3,
  parameter int DEPTH  = 2,
  parameter int COLS_B = 3,
  parameter int IW     = 2,
  parameter int JW     = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          res_valid,
  input logic [IW-1:0] res_row,
  input logic [JW-1:0] res_col,
  input logic          job_done,
  input logic          wr_a,
  input logic          wr_b,
  input logic          running
);

  logic [15:0] since;
  logic        job_open;
  int          prev_lin;
  int          lin;
  logic        is_last;

  assign lin     = int'(res_row) * COLS_B + int'(res_col);
  assign is_last = (lin == ROWS_A * COLS_B - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since    <= '0;
      job_open <= 1'b0;
      prev_lin <= 0;
    end else begin
      if (res_valid) begin
        since    <= 16'd1;
        prev_lin <= lin;
        job_open <= !is_last;
      end else if (since != 16'hFFFF) begin
        since <= since + 16'd1;
      end
    end
  end

  assert_one_matrix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_a, wr_b}));

  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && job_open) |-> (lin == prev_lin + 1));

  assert_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && job_open) |-> (since == 16'(DEPTH)));

  assert_done_after_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |-> $past(res_valid));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !job_done);

  assert_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |-> !res_valid);

  assert_run_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !(wr_a || wr_b));

  assert_idle_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !(wr_a || wr_b));

endmodule

bind mm_matmul mm_matmul_chk #(
  .ROWS_A(ROWS_A), .DEPTH(DEPTH), .COLS_B(COLS_B), .IW(IW), .JW(JW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .res_valid(res_valid),
  .res_row  (res_row),
  .res_col  (res_col),
  .job_done (job_done),
  .wr_a     (wr_a_en),
  .wr_b     (wr_bt_en),
  .running  (run_phase)
);

// File: tb/mm_matmul_bench.sv
`timescale 1ns/1ps
module mm_matmul_bench;

  localparam int R  = 3;
  localparam int K  = 2;
  localparam int N  = 3;
  localparam int DW = 8;
  localparam int SW = 2 * DW + 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic [DW-1:0]        in_data = '0;
  logic                 res_valid;
  logic [1:0]           res_row;
  logic [1:0]           res_col;
  logic signed [SW-1:0] res_data;
  logic                 job_done;

  always #10 clk = ~clk;

  mm_matmul #(.ROWS_A(R), .DEPTH(K), .COLS_B(N), .DW(DW)) u_mm_matmul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .res_valid(res_valid), .res_row(res_row), .res_col(res_col),
    .res_data(res_data), .job_done(job_done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  int ma [R][K];
  int mb [N][K];
  int expc [R][N];

  int  got = 0;
  int  load_end = 0;
  int  last_out = 0;
  bit  done_seen = 1'b0;
  bit  mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic compute_exp();
    for (int i = 0; i < R; i++)
      for (int j = 0; j < N; j++) begin
        int s;
        s = 0;
        for (int k = 0; k < K; k++) s += ma[i][k] * mb[j][k];
        expc[i][j] = s;
      end
  endtask

  // output monitor: results, order, spacing, done pulse
  always @(negedge clk) begin
    if (mon_on && res_valid) begin
      int ei, ej, ecyc;
      ei = got / N;
      ej = got % N;
      ecyc = (got == 0) ? load_end + K + 1 : last_out + K;
      chk(got < R * N, "R5 result count", got, R * N - 1);
      if (got < R * N) begin
        chk(int'(res_row) == ei, "R4 row index", int'(res_row), ei);
        chk(int'(res_col) == ej, "R4 col index", int'(res_col), ej);
        chk(int'(res_data) == expc[ei][ej], "R3 element value", int'(res_data), expc[ei][ej]);
      end
      chk(cyc == ecyc, "R5 result timing", cyc, ecyc);
      last_out = cyc;
      got++;
    end
    if (mon_on && job_done) begin
      chk(got == R * N, "R6 done after all results", got, R * N);
      chk(cyc == last_out + 1, "R6 done timing", cyc, last_out + 1);
      chk(!res_valid, "R6 done excl valid", int'(res_valid), 0);
      done_seen = 1'b1;
    end
  end

  task automatic send(input int val, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = DW'($urandom);
    end
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = val[DW-1:0];
  endtask

  // gap: idle cycles before each beat (R8); noise: junk beats during compute (R7)
  task automatic run_job(input int gap, input bit noise);
    compute_exp();
    got = 0;
    done_seen = 1'b0;
    for (int i = 0; i < R; i++) for (int k = 0; k < K; k++) send(ma[i][k], gap);
    for (int j = 0; j < N; j++) for (int k = 0; k < K; k++) send(mb[j][k], gap);
    load_end = cyc;
    if (noise) begin
      for (int t = 0; t < R * N * K - 2; t++) begin
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = DW'($urandom);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    for (int w = 0; w < 200 && !done_seen; w++) @(negedge clk);
    chk(done_seen, "R6 done pulse seen", int'(done_seen), 1);
    chk(got == R * N, "R5 results per job", got, R * N);
  endtask

  task automatic fill_random();
    for (int i = 0; i < R; i++) for (int k = 0; k < K; k++) ma[i][k] = int'($urandom_range(0, 255)) - 128;
    for (int j = 0; j < N; j++) for (int k = 0; k < K; k++) mb[j][k] = int'($urandom_range(0, 255)) - 128;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!res_valid, "R1 valid low in reset", int'(res_valid), 0);
    chk(!job_done, "R1 done low in reset", int'(job_done), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!res_valid && !job_done, "R1 idle after reset", int'({res_valid, job_done}), 0);
    end
    mon_on = 1'b1;

    // R2 R3: worked example, BT loaded as 1,0,1,4,2,0
    ma = '{'{2, 5}, '{7, -1}, '{0, 4}};
    mb = '{'{1, 0}, '{1, 4}, '{2, 0}};
    run_job(0, 1'b0);
    chk(expc[0][1] == 22 && expc[1][1] == 3 && expc[2][1] == 16, "R3 worked example reference",
        expc[0][1], 22);

    // R3: widest sums, all minimum values; R8: gapped load
    for (int i = 0; i < R; i++) for (int k = 0; k < K; k++) ma[i][k] = -128;
    for (int j = 0; j < N; j++) for (int k = 0; k < K; k++) mb[j][k] = -128;
    run_job(2, 1'b0);

    // R3 mixed extremes; R7 junk beats during compute
    for (int i = 0; i < R; i++) for (int k = 0; k < K; k++) ma[i][k] = ((i + k) % 2 == 0) ? 127 : -128;
    for (int j = 0; j < N; j++) for (int k = 0; k < K; k++) mb[j][k] = (j % 2 == 0) ? -128 : 127;
    run_job(0, 1'b1);

    // R2 R7: next job must load aligned after junk
    ma = '{'{2, 5}, '{7, -1}, '{0, 4}};
    mb = '{'{1, 0}, '{1, 4}, '{2, 0}};
    run_job(1, 1'b0);

    // random sweep of signed matrices
    for (int n = 0; n < 40; n++) begin
      fill_random();
      run_job(n % 3, (n % 4) == 3);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R6 watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule